// File: doc/BRIEF.md
# Context Firewall Access Checker

This block enforces isolation between execution contexts in hardware. It holds exactly one active context at a time. That context is either the privileged system context or one of several group contexts. For each object access, the block compares the active context with the context that owns the target object and answers grant or deny in the same cycle.

A call through a shared interface saves the caller's context in a small last-in-first-out stack and makes the callee's context active. A return restores the most recently saved context. The system context may reach every context, but no group context may reach objects owned by the system context. Calls that would overrun the stack, and returns with nothing saved, are refused and flagged.

Top module: `ctxfw_checker`

## Requirements
- R1: After a synchronous active-high reset, the active context is the system context (ID 0), the save stack is empty and both error outputs are low.
- R2: `acc_grant` and `acc_deny` are low while `acc_req` is low. While `acc_req` is high, exactly one of them is high, decided combinationally in the same cycle from the current active context.
- R3: An access whose owner context equals the active context is granted.
- R4: While the system context (ID 0) is active, every access is granted, whatever its owner.
- R5: An access from a group context to an object owned by a different group context is denied.
- R6: An access from a group context to an object owned by the system context (ID 0) is denied.
- R7: A call strobe with a non-full stack pushes the active context and makes `call_ctx` the active context from the next cycle on.
- R8: A return strobe with a non-empty stack pops the most recently saved context and makes it active from the next cycle on, in strict last-in-first-out order.
- R9: A call strobe while 8 contexts are saved leaves the active context and stack unchanged, and raises `err_overflow` for exactly the following cycle.
- R10: A return strobe with an empty stack keeps the active context and raises `err_underflow` for exactly the following cycle.
- R11: When call and return strobes arrive in the same cycle, the call is performed and the return is ignored.
- R12: Context IDs are 4 bits wide and ID 0 is reserved for the system context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access request valid |
| acc_owner | input | 4 | Context that owns the target object |
| call_req | input | 1 | Shared-interface call strobe |
| call_ctx | input | 4 | Context of the called interface |
| ret_req | input | 1 | Return strobe |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| active_ctx | output | 4 | Currently active context |
| err_overflow | output | 1 | Previous call was refused because the stack was full |
| err_underflow | output | 1 | Previous return was refused because the stack was empty |

## Verification
The bench builds the block with its default values: 4-bit context IDs and an 8-entry stack. The shallow stack lets a random mix of calls and returns reach both the full and the empty boundary many times per run. Owner and callee IDs are drawn from a narrow subset that includes ID 0. This makes same-context hits, system-owned targets and calls into the system context frequent, next to directed runs that fill the stack and then drain it past empty.

// File: rtl/ctxfw_pkg.sv
package ctxfw_pkg;
    parameter int unsigned CTX_W       = 4;
    parameter int unsigned STACK_DEPTH = 8;

    typedef logic [CTX_W-1:0] ctx_id_t;

    localparam ctx_id_t SYS_CTX = '0;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2
    } ctx_op_e;

    typedef struct packed {
        logic grant;
        logic deny;
    } verdict_t;

    function automatic logic may_access(ctx_id_t active, ctx_id_t owner);
        return (active == owner) || (active == SYS_CTX);
    endfunction
endpackage

// File: rtl/ctxfw_policy.sv
module ctxfw_policy
    import ctxfw_pkg::*;
(
    input  logic     req,
    input  ctx_id_t  active,
    input  ctx_id_t  owner,
    output verdict_t verdict
);
    logic allowed;

    always_comb begin
        allowed       = may_access(active, owner);
        verdict.grant = req && allowed;
        verdict.deny  = req && !allowed;
    end
endmodule

// File: rtl/ctxfw_stack.sv
module ctxfw_stack #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top_data,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] top_idx;

    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);
    assign top_idx = PTR_W'(cnt - CNT_W'(1));
    assign top_data = empty ? '0 : mem[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (push && !full && cnt == CNT_W'(i)) begin
                mem[i] <= push_data;
            end
        end
    end

    p_push_not_full_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_pop_not_empty_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_push_pop_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);
    p_push_grows_r7: assert property (@(posedge clk) disable iff (rst)
        push |=> !empty && top_data == $past(push_data));
endmodule

// File: rtl/ctxfw_switch.sv
module ctxfw_switch
    import ctxfw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    call_req,
    input  ctx_id_t call_ctx,
    input  logic    ret_req,
    input  logic    stk_full,
    input  logic    stk_empty,
    input  ctx_id_t stk_top,
    output ctx_id_t active,
    output logic    push,
    output logic    pop,
    output ctx_id_t push_data,
    output logic    err_ovf,
    output logic    err_unf
);
    ctx_op_e op;
    logic    ovf_now;
    logic    unf_now;

    always_comb begin
        if (call_req)     op = OP_CALL;
        else if (ret_req) op = OP_RET;
        else              op = OP_NONE;
    end

    assign ovf_now   = (op == OP_CALL) && stk_full;
    assign unf_now   = (op == OP_RET) && stk_empty;
    assign push      = (op == OP_CALL) && !stk_full;
    assign pop       = (op == OP_RET) && !stk_empty;
    assign push_data = active;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= SYS_CTX;
            err_ovf <= 1'b0;
            err_unf <= 1'b0;
        end else begin
            err_ovf <= ovf_now;
            err_unf <= unf_now;
            if (push)     active <= call_ctx;
            else if (pop) active <= stk_top;
        end
    end

    p_call_load_r7: assert property (@(posedge clk) disable iff (rst)
        call_req && !stk_full |=> active == $past(call_ctx));
    p_ret_restore_r8: assert property (@(posedge clk) disable iff (rst)
        ret_req && !call_req && !stk_empty |=> active == $past(stk_top));
    p_ovf_hold_r9: assert property (@(posedge clk) disable iff (rst)
        call_req && stk_full |=> $stable(active) && err_ovf);
    p_unf_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ret_req && !call_req && stk_empty |=> $stable(active) && err_unf);
    p_call_wins_r11: assert property (@(posedge clk) disable iff (rst)
        call_req && ret_req && !stk_full |=> active == $past(call_ctx));
    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(err_ovf && err_unf));
endmodule

// File: rtl/ctxfw_checker.sv
module ctxfw_checker
    import ctxfw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_req,
    input  logic [CTX_W-1:0]    acc_owner,
    input  logic                call_req,
    input  logic [CTX_W-1:0]    call_ctx,
    input  logic                ret_req,
    output logic                acc_grant,
    output logic                acc_deny,
    output logic [CTX_W-1:0]    active_ctx,
    output logic                err_overflow,
    output logic                err_underflow
);
    ctx_id_t  active;
    ctx_id_t  stk_top;
    ctx_id_t  push_data;
    logic     stk_full;
    logic     stk_empty;
    logic     push;
    logic     pop;
    verdict_t verdict;

    ctxfw_switch u_switch (
        .clk       (clk),
        .rst       (rst),
        .call_req  (call_req),
        .call_ctx  (call_ctx),
        .ret_req   (ret_req),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .stk_top   (stk_top),
        .active    (active),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .err_ovf   (err_overflow),
        .err_unf   (err_underflow)
    );

    ctxfw_stack #(
        .W     (CTX_W),
        .DEPTH (STACK_DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    ctxfw_policy u_policy (
        .req     (acc_req),
        .active  (active),
        .owner   (acc_owner),
        .verdict (verdict)
    );

    assign acc_grant  = verdict.grant;
    assign acc_deny   = verdict.deny;
    assign active_ctx = active;

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_req |-> !acc_grant && !acc_deny);
    p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> $onehot({acc_grant, acc_deny}));
    p_same_ctx_r3: assert property (@(posedge clk) disable iff (rst)
        acc_req && acc_owner == active_ctx |-> acc_grant);
    p_sys_reach_r4: assert property (@(posedge clk) disable iff (rst)
        acc_req && active_ctx == SYS_CTX |-> acc_grant);
    p_cross_group_r5: assert property (@(posedge clk) disable iff (rst)
        acc_req && active_ctx != SYS_CTX && acc_owner != SYS_CTX
        && acc_owner != active_ctx |-> acc_deny);
    p_sys_guarded_r6: assert property (@(posedge clk) disable iff (rst)
        acc_req && active_ctx != SYS_CTX && acc_owner == SYS_CTX |-> acc_deny);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> active_ctx == SYS_CTX && !err_overflow && !err_underflow);
endmodule

// File: tb/test_ctxfw_checker.sv
`timescale 1ns/1ps
module test_ctxfw_checker;
    import ctxfw_pkg::*;

    localparam int DEPTH = STACK_DEPTH;

    logic    clk = 1'b0;
    logic    rst = 1'b1;
    logic    acc_req = 1'b0;
    ctx_id_t acc_owner = '0;
    logic    call_req = 1'b0;
    ctx_id_t call_ctx = '0;
    logic    ret_req = 1'b0;
    logic    acc_grant, acc_deny, err_overflow, err_underflow;
    ctx_id_t active_ctx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    ctx_id_t m_act;
    ctx_id_t m_stk [DEPTH];
    int      m_cnt;

    always #4 clk = ~clk;

    ctxfw_checker i_ctxfw_checker (
        .clk           (clk),
        .rst           (rst),
        .acc_req       (acc_req),
        .acc_owner     (acc_owner),
        .call_req      (call_req),
        .call_ctx      (call_ctx),
        .ret_req       (ret_req),
        .acc_grant     (acc_grant),
        .acc_deny      (acc_deny),
        .active_ctx    (active_ctx),
        .err_overflow  (err_overflow),
        .err_underflow (err_underflow)
    );

    function automatic bit exp_allowed(ctx_id_t act, ctx_id_t own);
        if (act == 4'd0) return 1'b1;
        return act == own;
    endfunction

    function automatic string access_tag(bit req, ctx_id_t act, ctx_id_t own);
        if (!req)        return "R2";
        if (act == own)  return "R3";
        if (act == 4'd0) return "R4";
        if (own == 4'd0) return "R6";
        return "R5";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step(bit a, ctx_id_t own, bit c, ctx_id_t cc, bit r);
        bit    ok;
        bit    e_ovf;
        bit    e_unf;
        string t;
        @(negedge clk);
        acc_req = a; acc_owner = own; call_req = c; call_ctx = cc; ret_req = r;
        #1;
        ok = exp_allowed(m_act, own);
        t  = access_tag(a, m_act, own);
        check(t, "grant", int'(acc_grant), int'(a && ok));
        check(t, "deny",  int'(acc_deny),  int'(a && !ok));
        e_ovf = 1'b0; e_unf = 1'b0;
        if (c) begin
            t = r ? "R11" : "R7";
            if (m_cnt == DEPTH) begin
                e_ovf = 1'b1; t = "R9";
            end else begin
                m_stk[m_cnt] = m_act; m_cnt++; m_act = cc;
            end
        end else if (r) begin
            t = "R8";
            if (m_cnt == 0) begin
                e_unf = 1'b1; t = "R10";
            end else begin
                m_cnt--; m_act = m_stk[m_cnt];
            end
        end else begin
            t = "R8";
        end
        @(posedge clk);
        #1;
        check(t, "active_ctx", int'(active_ctx), int'(m_act));
        check("R9", "err_overflow", int'(err_overflow), int'(e_ovf));
        check("R10", "err_underflow", int'(err_underflow), int'(e_unf));
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_act = '0; m_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state, R12: system ID is 0
        check("R1", "active_ctx after reset", int'(active_ctx), 0);
        check("R1", "err_overflow after reset", int'(err_overflow), 0);
        check("R1", "err_underflow after reset", int'(err_underflow), 0);
        // R1/R10: stack starts empty, so a first return underflows
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
        // R4: system reaches every owner
        for (int k = 0; k < 16; k++) step(1'b1, ctx_id_t'(k), 1'b0, 4'd0, 1'b0);
        // R7, R9: fill the stack, then overflow
        for (int k = 1; k <= DEPTH; k++) step(1'b0, 4'd0, 1'b1, ctx_id_t'(k + 3), 1'b0);
        step(1'b1, 4'd11, 1'b1, 4'd2, 1'b0);
        step(1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
        step(1'b1, 4'd5, 1'b0, 4'd0, 1'b0);
        // R8, R10: drain in LIFO order, then one extra return
        for (int k = 0; k <= DEPTH; k++) step(1'b1, ctx_id_t'(k), 1'b0, 4'd0, 1'b1);
        // R11: simultaneous call and return
        step(1'b0, 4'd0, 1'b1, 4'd7, 1'b1);
        step(1'b1, 4'd7, 1'b1, 4'd9, 1'b1);
        step(1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
        step(1'b0, 4'd0, 1'b0, 4'd0, 1'b1);
        // random mix, narrow ID range
        for (int n = 0; n < 4000; n++) begin
            int sel;
            bit c;
            bit r;
            sel = $urandom_range(0, 99);
            c = sel < 30;
            r = (sel >= 25) && (sel < 60);
            step(1'($urandom_range(0, 3) != 0),
                 ctx_id_t'($urandom_range(0, 3)),
                 c,
                 ctx_id_t'($urandom_range(0, 3)),
                 r);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule